// File: doc/BRIEF.md
# Wait-Extended Read Servant

This block answers single-word read requests from a bus master. The master raises `req` and keeps it high until it has taken the word. If the word can be presented within a fixed access window, the servant drives it and never touches the wait line. The read then completes with plain strobe timing. If the word cannot arrive in time, the servant raises `bus_wait` no later than the end of the window. It drops `bus_wait` in the same cycle that it presents the data.

Each request sets its own internal latency through `req_lat`, or a fixed latency comes from a parameter. The word itself comes from a simple source port: a data word plus a ready flag. The servant captures the word only once the latency has elapsed and the source reports ready. In handshake mode the servant ignores the time window. It never raises `bus_wait` and instead marks the delivered word with `ack`. After a delivery, the servant takes a new request only once `req` has been seen low.

Top module: `strobe_wait_servant`

## Requirements
- R1: After a synchronous active-high `rst`, `rd_valid`, `bus_wait`, `ack` and `rd_data` are all zero and the servant is idle.
- R2: The acceptance edge is the first rising edge at which an idle servant samples `req` high; it is counted as edge 0. The load edge D is the first edge n ≥ 0 at which n ≥ latency and `src_ready` is high. `rd_valid` rises right after edge D. When D ≤ TACCESS−1, `bus_wait` stays low for the whole read.
- R3: When latency ≥ TACCESS and handshake mode is off, `bus_wait` is high from right after edge 0 up to edge D. It falls in the same cycle that `rd_valid` rises.
- R4: When latency < TACCESS but the source is not ready in time, handshake mode is off and D > TACCESS−1, `bus_wait` rises right after edge TACCESS−1. It stays high until data is valid.
- R5: `rd_data` equals the `src_word` sampled at edge D and stays stable while `req` is high. `rd_data` is zero whenever `rd_valid` is low.
- R6: `bus_wait` and `rd_valid` are never high together.
- R7: Once the word is valid, the first edge that samples `req` low clears `rd_valid`, `rd_data`, `bus_wait` and `ack`. While `req` stays high after delivery, no new read starts. One low cycle of `req` is enough to re-arm the servant.
- R8: With `hs_mode` = 1, `ack` rises together with `rd_valid` and `bus_wait` is never raised. With `hs_mode` = 0, `ack` stays low.
- R9: If `req` falls before the word is delivered, the next edge returns the servant to idle with all outputs cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request from the master, held until data is taken |
| req_lat | input | LAT_W | Per-request internal latency in cycles, sampled at acceptance |
| hs_mode | input | 1 | 1 selects handshake mode (ack, no wait); change only while idle |
| src_ready | input | 1 | Source word is available |
| src_word | input | DATA_W | Word from the data source |
| rd_data | output | DATA_W | Registered read data, zero when not valid |
| rd_valid | output | 1 | Registered flag marking `rd_data` valid |
| bus_wait | output | 1 | Registered wait line, raised for slow reads |
| ack | output | 1 | Registered acknowledge in handshake mode |

## Verification
The bench sweeps every latency against a range of source-ready delays in both modes. It targets three boundaries. The first is a latency of exactly TACCESS−1 against TACCESS; if that boundary is off by one, wait shows up on a read that could have been fast, or is missing on a read that could not. The second is a source that becomes ready only after the window; a design that looked only at latency would leave the master waiting without wait asserted. The third is a word that changes every cycle; a design that captured it a cycle early or late would return the neighbouring value. The bench also holds `req` high after delivery, drops it for exactly one cycle, and aborts a slow read, so that a servant that restarts on a held request, needs a longer gap, or leaves wait stuck after an abort is caught.

// File: rtl/swsv_pkg.sv
package swsv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2
  } swsv_state_e;

  // The word may be taken at edge index `elapsed` once latency has run out
  // and the source reports ready.
  function automatic logic can_load(input int unsigned elapsed,
                                    input int unsigned lat,
                                    input logic        ready);
    return (elapsed >= lat) && ready;
  endfunction

  // Wait must be raised now if the latency alone already misses the window,
  // or if this edge is the last one that could still make the window.
  function automatic logic must_wait(input int unsigned elapsed,
                                     input int unsigned lat,
                                     input int unsigned taccess);
    return (lat >= taccess) || (elapsed + 1 >= taccess);
  endfunction

endpackage

// File: rtl/swsv_timer.sv
module swsv_timer #(
  parameter int LAT_W = 3,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_ev,
  input  logic             fetching,
  input  logic [LAT_W-1:0] lat_sel,
  output logic [CNT_W-1:0] elapsed_q,
  output logic [LAT_W-1:0] lat_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
      lat_q     <= '0;
    end else if (accept_ev) begin
      elapsed_q <= CNT_W'(1);
      lat_q     <= lat_sel;
    end else if (fetching && elapsed_q != CNT_MAX) begin
      elapsed_q <= elapsed_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/swsv_ctrl.sv
module swsv_ctrl
  import swsv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        hs_mode,
  input  logic        hit,
  input  logic        slow,
  output logic        fetching,
  output logic        accept_ev,
  output logic        load_ev,
  output logic        wait_set_ev,
  output logic        clear_ev
);
  swsv_state_e state_q, state_d;
  logic        idle, holding, active, abort_ev, release_ev;

  assign idle        = (state_q == ST_IDLE);
  assign fetching    = (state_q == ST_FETCH);
  assign holding     = (state_q == ST_HOLD);
  assign active      = (idle | fetching) & req;
  assign accept_ev   = idle & req;
  assign load_ev     = active & hit;
  assign wait_set_ev = active & ~hit & ~hs_mode & slow;
  assign abort_ev    = fetching & ~req;
  assign release_ev  = holding & ~req;
  assign clear_ev    = abort_ev | release_ev;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req) state_d = hit ? ST_HOLD : ST_FETCH;
      ST_FETCH: if (!req) state_d = ST_IDLE;
                else if (hit) state_d = ST_HOLD;
      ST_HOLD:  if (!req) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/swsv_outreg.sv
module swsv_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ev,
  input  logic              wait_set_ev,
  input  logic              clear_ev,
  input  logic              hs_mode,
  input  logic [DATA_W-1:0] src_word,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              wait_q,
  output logic              ack_q
);
  always_ff @(posedge clk) begin
    if (rst || clear_ev) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      wait_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else if (load_ev) begin
      data_q  <= src_word;
      valid_q <= 1'b1;
      wait_q  <= 1'b0;
      ack_q   <= hs_mode;
    end else if (wait_set_ev) begin
      wait_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_wait_servant.sv
module strobe_wait_servant
  import swsv_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int LAT_W        = 3,
  parameter int TACCESS      = 3,
  parameter bit USE_LAT_PORT = 1'b1,
  parameter int DEF_LAT      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [LAT_W-1:0]  req_lat,
  input  logic              hs_mode,
  input  logic              src_ready,
  input  logic [DATA_W-1:0] src_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bus_wait,
  output logic              ack
);
  localparam int CNT_BASE = (LAT_W > $clog2(TACCESS + 1)) ? LAT_W : $clog2(TACCESS + 1);
  localparam int CNT_W    = CNT_BASE + 1;

  logic [LAT_W-1:0] lat_sel, lat_q, cur_lat;
  logic [CNT_W-1:0] elapsed_q, cur_e;
  logic             fetching, accept_ev, load_ev, wait_set_ev, clear_ev;
  logic             hit, slow;

  generate
    if (USE_LAT_PORT) begin : g_lat_port
      assign lat_sel = req_lat;
    end else begin : g_lat_fixed
      logic unused_lat;
      assign unused_lat = ^req_lat;
      assign lat_sel    = LAT_W'(DEF_LAT);
    end
  endgenerate

  // Edge index and latency in force at the current edge: edge 0 uses the
  // latency presented with the request itself.
  assign cur_e   = fetching ? elapsed_q : '0;
  assign cur_lat = fetching ? lat_q : lat_sel;
  assign hit     = can_load(32'(cur_e), 32'(cur_lat), src_ready);
  assign slow    = must_wait(32'(cur_e), 32'(cur_lat), TACCESS);

  swsv_timer #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .accept_ev (accept_ev),
    .fetching  (fetching),
    .lat_sel   (lat_sel),
    .elapsed_q (elapsed_q),
    .lat_q     (lat_q)
  );

  swsv_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .hs_mode     (hs_mode),
    .hit         (hit),
    .slow        (slow),
    .fetching    (fetching),
    .accept_ev   (accept_ev),
    .load_ev     (load_ev),
    .wait_set_ev (wait_set_ev),
    .clear_ev    (clear_ev)
  );

  swsv_outreg #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .load_ev     (load_ev),
    .wait_set_ev (wait_set_ev),
    .clear_ev    (clear_ev),
    .hs_mode     (hs_mode),
    .src_word    (src_word),
    .data_q      (rd_data),
    .valid_q     (rd_valid),
    .wait_q      (bus_wait),
    .ack_q       (ack)
  );
endmodule

// File: rtl/swsv_checker.sv
module swsv_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              hs_mode,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              bus_wait,
  input logic              ack,
  input logic              load_ev,
  input logic              clear_ev
);
  p_wait_valid_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_wait && rd_valid));

  p_zero_data_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && req) |=> (rd_valid && $stable(rd_data)));

  p_release_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !req) |=> (!rd_valid && !bus_wait && !ack));

  p_ack_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    ack |-> rd_valid);

  p_hs_no_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (hs_mode && !bus_wait) |=> !bus_wait);

  p_wait_ends_with_data_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_wait) && $past(req)) |-> rd_valid);

  p_abort_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (!req && !rd_valid) |=> (!bus_wait && !rd_valid));

  p_load_sets_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (load_ev && !clear_ev) |=> rd_valid);
endmodule

bind strobe_wait_servant swsv_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .hs_mode  (hs_mode),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .bus_wait (bus_wait),
  .ack      (ack),
  .load_ev  (load_ev),
  .clear_ev (clear_ev)
);

// File: tb/strobe_wait_servant_tb.sv
module strobe_wait_servant_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int LW   = 3;
  localparam int TACC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [LW-1:0] req_lat = '0;
  logic          hs_mode = 1'b0;
  logic          src_ready = 1'b0;
  logic [DW-1:0] src_word = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, bus_wait, ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_wait_servant #(.DATA_W(DW), .LAT_W(LW), .TACCESS(TACC), .USE_LAT_PORT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_lat(req_lat), .hs_mode(hs_mode),
    .src_ready(src_ready), .src_word(src_word), .rd_data(rd_data),
    .rd_valid(rd_valid), .bus_wait(bus_wait), .ack(ack)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One read: latency L, source ready from edge R on, word = base + edge index.
  task automatic run_read(input int L, input int R, input bit hs, input logic [DW-1:0] base);
    int D;
    D = (L > R) ? L : R;
    @(negedge clk);
    hs_mode   = hs;
    req_lat   = LW'(L);
    req       = 1'b1;
    src_ready = (R == 0);
    src_word  = base;
    for (int n = 0; n <= D + 2; n++) begin
      logic          ev, ew, ea;
      logic [DW-1:0] ed;
      string         wtag;
      @(posedge clk);
      @(negedge clk);
      ev   = (n >= D);
      ew   = !hs && (n < D) && ((L >= TACC) || (n >= TACC - 1));
      ea   = hs && (n >= D);
      ed   = (n >= D) ? DW'(base + DW'(D)) : '0;
      wtag = hs ? "R8" : ((L >= TACC) ? "R3" : ((D > TACC - 1) ? "R4" : "R2"));
      chk((D <= TACC - 1) ? "R2" : "R3", "rd_valid", int'(rd_valid), int'(ev));
      chk(wtag, "bus_wait", int'(bus_wait), int'(ew));
      chk("R8", "ack", int'(ack), int'(ea));
      chk("R5", "rd_data", int'(rd_data), int'(ed));
      if (bus_wait && rd_valid) chk("R6", "wait and valid together", 1, 0);
      src_ready = (n + 1 >= R);
      src_word  = DW'(base + DW'(n + 1));
    end
    // Held req after delivery did not restart (R7); now drop it for one cycle.
    req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "rd_valid after release", int'(rd_valid), 0);
    chk("R7", "bus_wait after release", int'(bus_wait), 0);
    chk("R7", "ack after release", int'(ack), 0);
    chk("R7", "rd_data after release", int'(rd_data), 0);
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rd_valid in reset", int'(rd_valid), 0);
    chk("R1", "bus_wait in reset", int'(bus_wait), 0);
    chk("R1", "ack in reset", int'(ack), 0);
    chk("R1", "rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rd_valid idle", int'(rd_valid), 0);

    for (int hs = 0; hs < 2; hs++)
      for (int L = 0; L < (1 << LW); L++)
        for (int R = 0; R < 6; R++) begin
          run_read(L, R, hs[0], DW'(8'h21 + 8'(k * 13)));
          k++;
        end

    // R9: abort a slow read, then a fast read must still work.
    @(negedge clk);
    hs_mode = 1'b0; req_lat = 3'd7; req = 1'b1; src_ready = 1'b1; src_word = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "bus_wait before abort", int'(bus_wait), 1);
    req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "bus_wait after abort", int'(bus_wait), 0);
    chk("R9", "rd_valid after abort", int'(rd_valid), 0);
    run_read(0, 0, 1'b0, 8'hC3);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule